// File: doc/BRIEF.md
# Zero-Page Second-Accumulator Execution Unit

This unit executes the accumulator-class arithmetic and logic operations of a small 8-bit processor core. It has two working modes. In the normal mode the accumulator supplied by the core is the destination. In the redirect mode the page-zero byte whose address is held in the X register becomes the destination and is updated in place. A single flag in the processor status word selects the mode. The unit holds that status word and sets or clears the flag on two dedicated operation codes.

In redirect mode the instruction carries no operand address, and the unit has no address input. It forms the page-zero address `{0, X}` directly, reads the byte, combines it with the second operand and writes the result back. The core's accumulator is never written in this mode. The instruction fetch, the full decoder and every other addressing mode stay outside the unit. The core presents one operation at a time with a strobe. The unit reports when the operation is in flight and when it completes.

Top module: `zpacc_unit`

## Requirements
- R1: After reset the status word is all zero (redirect flag clear), and busy, done, memory read, memory write and accumulator write-enable are all low.
- R2: Operation code 5 sets status bit 6 (the redirect flag) and code 6 clears it, both on the clock edge that accepts the strobe, with no memory access and no done pulse.
- R3: With status bit 6 at 0, an ALU code (0 add-with-carry, 1 subtract-with-borrow, 2 AND, 3 OR, 4 XOR) combines the accumulator input with the operand. In the cycle after acceptance it shows the result on the accumulator output with write-enable and done high and no memory access.
- R4: With status bit 6 at 1, an ALU code raises a memory read in the cycle after acceptance, at address `{0, X}` (upper address bits zero). No operand address is fetched.
- R5: In redirect mode, once the read data has returned (RD_LAT cycles), the unit writes the result to the same address, with done high, in that cycle. The accumulator write-enable stays low throughout.
- R6: Add-with-carry forms A + B + C. C (status bit 0) becomes the carry out and V (status bit 5) becomes the signed overflow.
- R7: Subtract-with-borrow forms A − B − (1 − C). C becomes 1 when no borrow occurs, and V becomes the signed overflow.
- R8: AND, OR and XOR leave C and V unchanged.
- R9: At the end of the done cycle, in either mode, N (status bit 7) takes the result's top bit and Z (status bit 1) is set exactly when the result is zero.
- R10: Busy is high from the cycle after an ALU code is accepted through the done cycle. A strobe that arrives while busy is high is ignored, and code 7 is ignored entirely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation strobe |
| op_code | input | 3 | Operation code |
| operand_i | input | DATA_W | Second operand |
| x_i | input | DATA_W | X register, page-zero pointer |
| acc_i | input | DATA_W | Current accumulator |
| mem_rdata_i | input | DATA_W | Memory read data |
| mem_addr_o | output | ADDR_W | Memory address |
| mem_rd_o | output | 1 | Memory read request |
| mem_wr_o | output | 1 | Memory write request |
| mem_wdata_o | output | DATA_W | Memory write data |
| acc_o | output | DATA_W | Result toward the accumulator |
| acc_we_o | output | 1 | Accumulator write enable |
| status_o | output | SR_W | Status word |
| busy_o | output | 1 | Operation in flight |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the unit with its default parameters: an 8-bit datapath, a 16-bit address and a one-cycle read latency. With these values the sign, carry and overflow boundaries (0x7F+1, 0xFF+1, 0x50−0xB0) and the page-zero edge at X = 0xFF can be hit with single directed operands. With the one-cycle latency the read-then-write sequence also has an exact cycle count to check. Holding the strobe with a mode-clear code across the read and write cycles shows that the in-flight operation shields the flag.

// File: rtl/zpacc_pkg.sv
package zpacc_pkg;

   typedef enum logic [2:0] {
      OP_ADC  = 3'd0,
      OP_SBC  = 3'd1,
      OP_AND  = 3'd2,
      OP_ORA  = 3'd3,
      OP_EOR  = 3'd4,
      OP_SETM = 3'd5,
      OP_CLRM = 3'd6,
      OP_NONE = 3'd7
   } zop_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_EXEC  = 2'd1,
      ST_READ  = 2'd2,
      ST_WRITE = 2'd3
   } zst_e;

   function automatic logic is_alu(zop_e o);
      return (o == OP_ADC) || (o == OP_SBC) || (o == OP_AND) ||
             (o == OP_ORA) || (o == OP_EOR);
   endfunction

   function automatic logic is_arith(zop_e o);
      return (o == OP_ADC) || (o == OP_SBC);
   endfunction

endpackage

// File: rtl/zpacc_alu.sv
module zpacc_alu
   import zpacc_pkg::*;
#(
   parameter int W = 8
) (
   input  zop_e         op,
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         cin,
   output logic [W-1:0] res,
   output logic         c_out,
   output logic         v_out,
   output logic         n_out,
   output logic         z_out
);
   localparam int MSB = W - 1;

   logic [W-1:0] b_eff;
   logic [W:0]   sum;

   always_comb begin
      b_eff = (op == OP_SBC) ? ~b : b;
      sum   = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, cin};
      unique case (op)
         OP_ADC, OP_SBC: res = sum[W-1:0];
         OP_AND:         res = a & b;
         OP_ORA:         res = a | b;
         OP_EOR:         res = a ^ b;
         default:        res = a;
      endcase
      c_out = sum[W];
      v_out = (a[MSB] == b_eff[MSB]) && (sum[MSB] != a[MSB]);
      n_out = res[MSB];
      z_out = (res == '0);
   end
endmodule

// File: rtl/zpacc_status.sv
module zpacc_status #(
   parameter int SR_W     = 8,
   parameter int C_POS    = 0,
   parameter int Z_POS    = 1,
   parameter int V_POS    = 5,
   parameter int MODE_POS = 6,
   parameter int N_POS    = 7
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            set_mode,
   input  logic            clr_mode,
   input  logic            upd_nz,
   input  logic            upd_cv,
   input  logic            n_in,
   input  logic            z_in,
   input  logic            c_in,
   input  logic            v_in,
   output logic [SR_W-1:0] status,
   output logic            mode,
   output logic            carry
);
   logic [SR_W-1:0] sr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr_q <= '0;
      end else begin
         if (set_mode) sr_q[MODE_POS] <= 1'b1;
         else if (clr_mode) sr_q[MODE_POS] <= 1'b0;
         if (upd_nz) begin
            sr_q[N_POS] <= n_in;
            sr_q[Z_POS] <= z_in;
         end
         if (upd_cv) begin
            sr_q[C_POS] <= c_in;
            sr_q[V_POS] <= v_in;
         end
      end
   end

   assign status = sr_q;
   assign mode   = sr_q[MODE_POS];
   assign carry  = sr_q[C_POS];
endmodule

// File: rtl/zpacc_seq.sv
module zpacc_seq
   import zpacc_pkg::*;
#(
   parameter int RD_LAT = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic redirect,
   output zst_e state_o,
   output logic busy,
   output logic done,
   output logic rd_req,
   output logic wr_req
);
   localparam int CNT_W = (RD_LAT > 1) ? $clog2(RD_LAT) : 1;
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RD_LAT - 1);

   zst_e             st_q, st_d;
   logic [CNT_W-1:0] cnt_q, cnt_d;

   always_comb begin
      st_d  = st_q;
      cnt_d = cnt_q;
      unique case (st_q)
         ST_IDLE: begin
            cnt_d = '0;
            if (start) st_d = redirect ? ST_READ : ST_EXEC;
         end
         ST_EXEC:  st_d = ST_IDLE;
         ST_READ: begin
            if (cnt_q == CNT_LAST) st_d = ST_WRITE;
            else cnt_d = cnt_q + 1'b1;
         end
         ST_WRITE: st_d = ST_IDLE;
         default:  st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ST_IDLE;
         cnt_q <= '0;
      end else begin
         st_q  <= st_d;
         cnt_q <= cnt_d;
      end
   end

   assign state_o = st_q;
   assign busy    = (st_q != ST_IDLE);
   assign done    = (st_q == ST_EXEC) || (st_q == ST_WRITE);
   assign rd_req  = (st_q == ST_READ) && (cnt_q == '0);
   assign wr_req  = (st_q == ST_WRITE);
endmodule

// File: rtl/zpacc_unit.sv
module zpacc_unit
   import zpacc_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int ADDR_W   = 16,
   parameter int RD_LAT   = 1,
   parameter int SR_W     = 8,
   parameter int C_POS    = 0,
   parameter int Z_POS    = 1,
   parameter int V_POS    = 5,
   parameter int MODE_POS = 6,
   parameter int N_POS    = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_valid,
   input  logic [2:0]        op_code,
   input  logic [DATA_W-1:0] operand_i,
   input  logic [DATA_W-1:0] x_i,
   input  logic [DATA_W-1:0] acc_i,
   input  logic [DATA_W-1:0] mem_rdata_i,
   output logic [ADDR_W-1:0] mem_addr_o,
   output logic              mem_rd_o,
   output logic              mem_wr_o,
   output logic [DATA_W-1:0] mem_wdata_o,
   output logic [DATA_W-1:0] acc_o,
   output logic              acc_we_o,
   output logic [SR_W-1:0]   status_o,
   output logic              busy_o,
   output logic              done_o
);
   localparam int PAD_W = ADDR_W - DATA_W;

   // elaboration-time parameter checks
   generate
      if (DATA_W < 2) begin : g_bad_data
         $error("zpacc_unit: DATA_W must be at least 2");
      end
      if (ADDR_W < DATA_W) begin : g_bad_addr
         $error("zpacc_unit: ADDR_W must not be below DATA_W");
      end
      if (RD_LAT < 1) begin : g_bad_lat
         $error("zpacc_unit: RD_LAT must be at least 1");
      end
      if (C_POS >= SR_W || Z_POS >= SR_W || V_POS >= SR_W ||
          MODE_POS >= SR_W || N_POS >= SR_W) begin : g_bad_pos
         $error("zpacc_unit: a flag position lies outside the status word");
      end
      if (C_POS == Z_POS || C_POS == V_POS || C_POS == MODE_POS || C_POS == N_POS ||
          Z_POS == V_POS || Z_POS == MODE_POS || Z_POS == N_POS ||
          V_POS == MODE_POS || V_POS == N_POS || MODE_POS == N_POS) begin : g_dup_pos
         $error("zpacc_unit: flag positions must be distinct");
      end
   endgenerate

   zop_e              op_in;
   zop_e              op_q;
   logic [DATA_W-1:0] a_q, b_q, x_q;
   logic              accept, start, set_m, clr_m;
   logic              mode, carry;
   zst_e              state;
   logic              busy, done, rd_req, wr_req;
   logic [DATA_W-1:0] alu_a, alu_res;
   logic              alu_c, alu_v, alu_n, alu_z;

   assign op_in  = zop_e'(op_code);
   assign accept = op_valid && !busy;
   assign start  = accept && is_alu(op_in);
   assign set_m  = accept && (op_in == OP_SETM);
   assign clr_m  = accept && (op_in == OP_CLRM);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_q <= OP_NONE;
         a_q  <= '0;
         b_q  <= '0;
         x_q  <= '0;
      end else if (start) begin
         op_q <= op_in;
         a_q  <= acc_i;
         b_q  <= operand_i;
         x_q  <= x_i;
      end
   end

   zpacc_seq #(.RD_LAT(RD_LAT)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .redirect (mode),
      .state_o  (state),
      .busy     (busy),
      .done     (done),
      .rd_req   (rd_req),
      .wr_req   (wr_req)
   );

   assign alu_a = (state == ST_WRITE) ? mem_rdata_i : a_q;

   zpacc_alu #(.W(DATA_W)) u_alu (
      .op    (op_q),
      .a     (alu_a),
      .b     (b_q),
      .cin   (carry),
      .res   (alu_res),
      .c_out (alu_c),
      .v_out (alu_v),
      .n_out (alu_n),
      .z_out (alu_z)
   );

   zpacc_status #(
      .SR_W     (SR_W),
      .C_POS    (C_POS),
      .Z_POS    (Z_POS),
      .V_POS    (V_POS),
      .MODE_POS (MODE_POS),
      .N_POS    (N_POS)
   ) u_status (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_mode (set_m),
      .clr_mode (clr_m),
      .upd_nz   (done),
      .upd_cv   (done && is_arith(op_q)),
      .n_in     (alu_n),
      .z_in     (alu_z),
      .c_in     (alu_c),
      .v_in     (alu_v),
      .status   (status_o),
      .mode     (mode),
      .carry    (carry)
   );

   // page-zero address: X with the upper address bits forced to zero
   generate
      if (PAD_W > 0) begin : g_pad_addr
         assign mem_addr_o = {{PAD_W{1'b0}}, x_q};
      end else begin : g_flat_addr
         assign mem_addr_o = x_q;
      end
   endgenerate

   assign mem_rd_o    = rd_req;
   assign mem_wr_o    = wr_req;
   assign mem_wdata_o = alu_res;
   assign acc_o       = alu_res;
   assign acc_we_o    = (state == ST_EXEC);
   assign busy_o      = busy;
   assign done_o      = done;
endmodule

// File: rtl/zpacc_chk.sv
module zpacc_chk #(
   parameter int DATA_W   = 8,
   parameter int ADDR_W   = 16,
   parameter int SR_W     = 8,
   parameter int MODE_POS = 6,
   parameter int N_POS    = 7
) (
   input logic              clk,
   input logic              rst_n,
   input logic              op_valid,
   input logic [2:0]        op_code,
   input logic [ADDR_W-1:0] mem_addr_o,
   input logic              mem_rd_o,
   input logic              mem_wr_o,
   input logic [DATA_W-1:0] acc_o,
   input logic              acc_we_o,
   input logic [SR_W-1:0]   status_o,
   input logic              busy_o,
   input logic              done_o
);
   logic [ADDR_W-1:0] rd_addr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rd_addr_q <= '0;
      else if (mem_rd_o) rd_addr_q <= mem_addr_o;
   end

   // R2
   mode_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && !busy_o && op_code == 3'd5) |=> status_o[MODE_POS]);

   // R2
   mode_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && !busy_o && op_code == 3'd6) |=> !status_o[MODE_POS]);

   // R3
   acc_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
      acc_we_o |-> (!mem_rd_o && !mem_wr_o && done_o && !status_o[MODE_POS]));

   // R4
   zp_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_o |-> ((mem_addr_o >> DATA_W) == '0));

   // R5
   wr_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_o |-> (status_o[MODE_POS] && done_o && !acc_we_o));

   // R5
   wr_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_o |-> (mem_addr_o == rd_addr_q));

   // R9
   neg_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> (status_o[N_POS] == $past(acc_o[DATA_W-1])));

   // R10
   busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> $past(op_valid));

   // R10
   done_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> busy_o);

   // R10
   done_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !busy_o);
endmodule

bind zpacc_unit zpacc_chk #(
   .DATA_W   (DATA_W),
   .ADDR_W   (ADDR_W),
   .SR_W     (SR_W),
   .MODE_POS (MODE_POS),
   .N_POS    (N_POS)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .op_valid   (op_valid),
   .op_code    (op_code),
   .mem_addr_o (mem_addr_o),
   .mem_rd_o   (mem_rd_o),
   .mem_wr_o   (mem_wr_o),
   .acc_o      (acc_o),
   .acc_we_o   (acc_we_o),
   .status_o   (status_o),
   .busy_o     (busy_o),
   .done_o     (done_o)
);

// File: tb/sim_zpacc_unit.sv
`timescale 1ns/1ps
module sim_zpacc_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_valid = 1'b0;
   logic [2:0]  op_code = 3'd7;
   logic [7:0]  operand_i = 8'h00;
   logic [7:0]  x_i = 8'h00;
   logic [7:0]  acc_reg = 8'h00;
   logic [7:0]  mem_rdata = 8'h00;
   logic [15:0] mem_addr;
   logic        mem_rd, mem_wr, acc_we, busy, done;
   logic [7:0]  mem_wdata, acc_o;
   logic [7:0]  status;
   logic [7:0]  mem [256];
   int          checks = 0;
   int          errors = 0;
   int          wr_cnt = 0;

   always #10 clk = ~clk;

   zpacc_unit u0 (
      .clk         (clk),
      .rst_n       (rst_n),
      .op_valid    (op_valid),
      .op_code     (op_code),
      .operand_i   (operand_i),
      .x_i         (x_i),
      .acc_i       (acc_reg),
      .mem_rdata_i (mem_rdata),
      .mem_addr_o  (mem_addr),
      .mem_rd_o    (mem_rd),
      .mem_wr_o    (mem_wr),
      .mem_wdata_o (mem_wdata),
      .acc_o       (acc_o),
      .acc_we_o    (acc_we),
      .status_o    (status),
      .busy_o      (busy),
      .done_o      (done)
   );

   // page-zero memory, one-cycle read latency; external accumulator
   always @(posedge clk) begin
      if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];
      if (mem_wr) begin
         mem[mem_addr[7:0]] <= mem_wdata;
         wr_cnt <= wr_cnt + 1;
      end
      if (acc_we) acc_reg <= acc_o;
   end

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic issue(input logic [2:0] c, input logic [7:0] b);
      @(negedge clk);
      op_code   = c;
      operand_i = b;
      op_valid  = 1'b1;
      @(negedge clk);
      op_valid  = 1'b0;
   endtask

   task automatic acc_op(input string tag, input logic [2:0] c, input logic [7:0] a,
                         input logic [7:0] b, input logic [7:0] exp_res,
                         input logic [7:0] exp_st);
      @(negedge clk);
      acc_reg = a;
      issue(c, b);
      chk({tag, " R3 done"}, 16'(done), 16'h1);
      chk({tag, " R3 acc_we"}, 16'(acc_we), 16'h1);
      chk({tag, " R3 result"}, 16'(acc_o), 16'(exp_res));
      chk({tag, " R3 no mem"}, 16'({mem_rd, mem_wr}), 16'h0);
      @(negedge clk);
      chk({tag, " R9 status"}, 16'(status), 16'(exp_st));
      chk({tag, " R10 idle"}, 16'({busy, done}), 16'h0);
      chk({tag, " R3 acc"}, 16'(acc_reg), 16'(exp_res));
   endtask

   task automatic mem_op(input string tag, input logic [2:0] c, input logic [7:0] x,
                         input logic [7:0] m, input logic [7:0] b,
                         input logic [7:0] exp_res, input logic [7:0] exp_st);
      @(negedge clk);
      mem[x]  = m;
      x_i     = x;
      acc_reg = 8'h5A;
      issue(c, b);
      chk({tag, " R4 read"}, 16'({mem_rd, mem_wr, done}), 16'h4);
      chk({tag, " R4 addr"}, mem_addr, {8'h00, x});
      chk({tag, " R10 busy"}, 16'(busy), 16'h1);
      @(negedge clk);
      chk({tag, " R5 write"}, 16'({mem_wr, done, acc_we}), 16'h6);
      chk({tag, " R5 addr"}, mem_addr, {8'h00, x});
      chk({tag, " R5 data"}, 16'(mem_wdata), 16'(exp_res));
      @(negedge clk);
      chk({tag, " R9 status"}, 16'(status), 16'(exp_st));
      chk({tag, " R10 idle"}, 16'({busy, done}), 16'h0);
      chk({tag, " R5 mem"}, 16'(mem[x]), 16'(exp_res));
      chk({tag, " R5 acc kept"}, 16'(acc_reg), 16'h5A);
   endtask

   task automatic mode_op(input string tag, input logic [2:0] c, input logic [7:0] exp_st);
      issue(c, 8'h00);
      chk({tag, " R2 status"}, 16'(status), 16'(exp_st));
      chk({tag, " R2 quiet"}, 16'({busy, done, mem_rd, mem_wr, acc_we}), 16'h0);
   endtask

   task automatic t_reset();
      chk("R1 status", 16'(status), 16'h00);
      chk("R1 outputs", 16'({busy, done, mem_rd, mem_wr, acc_we}), 16'h0);
   endtask

   task automatic t_ignore_busy();
      int w0;
      @(negedge clk);
      mem[8'h33] = 8'h01;
      x_i        = 8'h33;
      w0         = wr_cnt;
      op_code    = 3'd0;
      operand_i  = 8'h01;
      op_valid   = 1'b1;
      @(negedge clk);
      op_code    = 3'd6;
      @(negedge clk);
      @(negedge clk);
      op_valid   = 1'b0;
      chk("R10 clear ignored while busy", 16'(status), 16'h40);
      chk("R10 single write", 16'(wr_cnt - w0), 16'h1);
      chk("R10 result", 16'(mem[8'h33]), 16'h03);
   endtask

   task automatic t_code7();
      issue(3'd7, 8'hFF);
      chk("R10 code7 quiet", 16'({busy, done, mem_rd, acc_we}), 16'h0);
      @(negedge clk);
      chk("R10 code7 status", 16'(status), 16'h40);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = 8'h00;
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      // R6 add with carry: overflow, then carry out
      acc_op("R6 add ovf", 3'd0, 8'h7F, 8'h01, 8'h80, 8'hA0);
      acc_op("R6 add carry", 3'd0, 8'hFF, 8'h01, 8'h00, 8'h03);
      // R7 subtract with borrow
      acc_op("R7 sub plain", 3'd1, 8'h50, 8'h30, 8'h20, 8'h01);
      acc_op("R7 sub ovf", 3'd1, 8'h50, 8'hB0, 8'hA0, 8'hA0);
      // R8 logic ops keep C and V
      acc_op("R8 and", 3'd2, 8'hF0, 8'h0F, 8'h00, 8'h22);
      acc_op("R8 or", 3'd3, 8'h80, 8'h01, 8'h81, 8'hA0);
      acc_op("R8 xor", 3'd4, 8'hFF, 8'hFF, 8'h00, 8'h22);
      acc_op("R7 sub borrow in", 3'd1, 8'h10, 8'h01, 8'h0E, 8'h01);
      mode_op("R2 set", 3'd5, 8'h41);
      mem_op("R4 adc zp", 3'd0, 8'h40, 8'h10, 8'h05, 8'h16, 8'h40);
      mem_op("R6 adc zp carry", 3'd0, 8'h80, 8'hFF, 8'h01, 8'h00, 8'h43);
      mem_op("R7 sbc zp", 3'd1, 8'h81, 8'h10, 8'h01, 8'h0F, 8'h41);
      mem_op("R8 or zp top", 3'd3, 8'hFF, 8'h0C, 8'hC0, 8'hCC, 8'hC1);
      t_ignore_busy();
      t_code7();
      mode_op("R2 clear", 3'd6, 8'h00);
      acc_op("R3 after clear", 3'd0, 8'h01, 8'h01, 8'h02, 8'h00);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule